// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a clocked request interface and an external asynchronous static RAM of 128K bytes. A client offers a request with a valid/ready handshake: a word address, a write flag, a write-framing choice and, for writes, one data byte. The block turns each accepted request into the sequence of levels on the memory's active-low select, output-enable and write-enable pins. Reads return one byte on a one-cycle response strobe.

All intervals of a memory cycle are given as nanosecond parameters. Each is turned into a whole number of clock cycles by rounding up. The block then holds every pin level for that many cycles. The shared data bus appears as an output byte, a drive enable and an input byte, which the pad ring joins into one tri-state bus. The sequencer keeps its own driver off whenever the memory could be driving. It waits out the memory's release delay before it drives again.

A write can be framed in two ways. In the first, select falls first and write-enable pulses inside it. In the second, write-enable falls first and select pulses inside it. In both, output-enable stays high for the whole write.

Top module: `sram_port_ctl`

## Requirements
- R1: While reset is high and in the cycle after it, select, output-enable and write-enable are high, the data driver is off, ready is high and the response strobe is low.
- R2: Ready is high only when the sequencer is idle, so each handshake starts exactly one memory cycle. After every transaction, select and write-enable return high and the driver turns off before the next request is accepted.
- R3: A read holds select and output-enable low together for N_RD = ceil(max(address access, select access, output-enable access, read cycle) / clock) cycles. The byte on the input bus is sampled on the last clock edge of that window. The response strobe is high for exactly one cycle, in the cycle after that edge.
- R4: The data driver is never on while select and output-enable are both low. It turns on only after at least N_HZ = ceil(release time / clock) cycles in which they were not both low.
- R5: Output-enable is high in every cycle in which write-enable is low, so the memory never drives during a write.
- R6: When the write-framing input is 0, select falls one cycle before write-enable does. The overlap of the two lows lasts exactly N_WP = ceil(max(write pulse, address-to-end, select-to-end, data setup) / clock) cycles, and write-enable rises first to end it.
- R7: When the write-framing input is 1, write-enable falls one cycle before select does. The overlap lasts N_WP cycles, and select rises first to end it.
- R8: The address pins stay constant for the whole overlap of low select and low write-enable. They change only on the clock edge that accepts a request.
- R9: The data driver is on, with a stable byte, for the whole overlap and for N_REC = max(ceil(recovery/clock), ceil(data hold/clock), N_WC-1-N_WP, 1) cycles after it. N_WC is the rounded-up write cycle.
- R10: A byte written to an address is returned by a later read of that address. This holds for every address and for both framing styles.
- R11: From acceptance until ready returns, a write is busy for 1+N_WP+N_REC cycles and a read for N_RD+N_HZ cycles. With a 4 ns clock and default timing these are 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wmode | input | 1 | Write framing: 0 = write-enable pulses inside select, 1 = select pulses inside write-enable |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle strobe: read byte available |
| rsp_rdata | output | DATA_W | Read byte |
| mem_addr | output | ADDR_W | Address pins of the memory |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | DATA_W | Byte to drive onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | DATA_W | Byte seen on the data bus |

## Verification
The properties assume the client changes nothing between handshakes that the sequencer depends on. They also assume the memory drives the bus only while select and output-enable are both low and write-enable is high. The bench memory model drives the input byte under exactly that condition and otherwise presents zero. The bench offers requests only at falling edges and holds valid for a single accepting cycle, waiting for ready before the next request. A sweep over every address of a 10-bit configuration uses both framing styles in two orders.

// File: rtl/sram_port_pkg.sv
`timescale 1ns/1ps
package sram_port_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RD_REL,
        ST_WR_SET,
        ST_WR_PULSE,
        ST_WR_REC
    } seq_st_e;

    // Levels presented to the memory pins for one sequencer state.
    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic drv;
    } pin_set_t;

    localparam pin_set_t PINS_QUIET = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};

    function automatic int ns2cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // cs_frame = 1 selects the style where write-enable is the outer strobe.
    function automatic pin_set_t pin_decode(input seq_st_e st, input logic cs_frame);
        pin_set_t p;
        p = PINS_QUIET;
        case (st)
            ST_RD: begin
                p.cs_n = 1'b0;
                p.oe_n = 1'b0;
            end
            ST_WR_SET, ST_WR_REC: begin
                p.cs_n = cs_frame;
                p.we_n = ~cs_frame;
                p.drv  = (st == ST_WR_REC);
            end
            ST_WR_PULSE: begin
                p.cs_n = 1'b0;
                p.we_n = 1'b0;
                p.drv  = 1'b1;
            end
            default: p = PINS_QUIET;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_req_hold.sv
`timescale 1ns/1ps
module sram_req_hold #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              mode_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              mode_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            mode_q <= 1'b0;
        end else if (take) begin
            addr_q <= addr_i;
            data_q <= data_i;
            mode_q <= mode_i;
        end
    end

endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
    import sram_port_pkg::*;
#(
    parameter int N_RD  = 5,
    parameter int N_WP  = 4,
    parameter int N_REC = 1,
    parameter int N_HZ  = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    take_i,
    input  logic    write_i,
    output seq_st_e st_q,
    output logic    ready_o,
    output logic    cap_o
);

    localparam int N_TOP = imax(imax(N_RD, N_WP), imax(N_REC, N_HZ));
    localparam int CNT_W = $clog2(N_TOP + 1);

    seq_st_e          st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        cap_o = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (take_i) begin
                    if (write_i) begin
                        st_d  = ST_WR_SET;
                        cnt_d = '0;
                    end else begin
                        st_d  = ST_RD;
                        cnt_d = CNT_W'(N_RD - 1);
                    end
                end
            end
            ST_RD: begin
                if (cnt_q == '0) begin
                    st_d  = ST_RD_REL;
                    cnt_d = CNT_W'(N_HZ - 1);
                    cap_o = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_RD_REL: begin
                if (cnt_q == '0) st_d = ST_IDLE;
                else             cnt_d = cnt_q - 1'b1;
            end
            ST_WR_SET: begin
                st_d  = ST_WR_PULSE;
                cnt_d = CNT_W'(N_WP - 1);
            end
            ST_WR_PULSE: begin
                if (cnt_q == '0) begin
                    st_d  = ST_WR_REC;
                    cnt_d = CNT_W'(N_REC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WR_REC: begin
                if (cnt_q == '0) st_d = ST_IDLE;
                else             cnt_d = cnt_q - 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign ready_o = (st_q == ST_IDLE);

endmodule

// File: rtl/sram_pin_reg.sv
`timescale 1ns/1ps
module sram_pin_reg
    import sram_port_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  seq_st_e st_i,
    input  logic    cs_frame_i,
    input  logic    cap_i,
    output logic    cs_n,
    output logic    oe_n,
    output logic    we_n,
    output logic    drv,
    output logic    cap_q
);

    pin_set_t pins_q;

    // Pins follow the state one cycle late, so the address register
    // settles a full cycle before any strobe moves.
    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q <= PINS_QUIET;
            cap_q  <= 1'b0;
        end else begin
            pins_q <= pin_decode(st_i, cs_frame_i);
            cap_q  <= cap_i;
        end
    end

    assign cs_n = pins_q.cs_n;
    assign oe_n = pins_q.oe_n;
    assign we_n = pins_q.we_n;
    assign drv  = pins_q.drv;

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= cap_i;
            if (cap_i) rsp_rdata <= dq_in;
        end
    end

endmodule

// File: rtl/sram_port_ctl.sv
`timescale 1ns/1ps
module sram_port_ctl
    import sram_port_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int CLK_NS  = 4,
    parameter int T_WC_NS = 20,
    parameter int T_WP_NS = 12,
    parameter int T_AW_NS = 15,
    parameter int T_CW_NS = 12,
    parameter int T_WR_NS = 2,
    parameter int T_DW_NS = 10,
    parameter int T_DH_NS = 1,
    parameter int T_AA_NS = 20,
    parameter int T_SA_NS = 20,
    parameter int T_OA_NS = 10,
    parameter int T_RC_NS = 20,
    parameter int T_HZ_NS = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_wmode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int N_RD  = imax(1, imax(imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_SA_NS, CLK_NS)),
                                        imax(ns2cyc(T_OA_NS, CLK_NS), ns2cyc(T_RC_NS, CLK_NS))));
    localparam int N_WP  = imax(1, imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                        imax(ns2cyc(T_CW_NS, CLK_NS), ns2cyc(T_DW_NS, CLK_NS))));
    localparam int N_WC  = ns2cyc(T_WC_NS, CLK_NS);
    localparam int N_REC = imax(1, imax(imax(ns2cyc(T_WR_NS, CLK_NS), ns2cyc(T_DH_NS, CLK_NS)),
                                        N_WC - 1 - N_WP));
    localparam int N_HZ  = imax(1, ns2cyc(T_HZ_NS, CLK_NS));

    seq_st_e st_q;
    logic    take, cap, cap_q, mode_q;

    assign take = req_valid && req_ready;

    sram_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .addr_i (req_addr),
        .data_i (req_wdata),
        .mode_i (req_wmode),
        .addr_q (mem_addr),
        .data_q (mem_dq_out),
        .mode_q (mode_q)
    );

    sram_seq_ctrl #(.N_RD(N_RD), .N_WP(N_WP), .N_REC(N_REC), .N_HZ(N_HZ)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .take_i  (take),
        .write_i (req_write),
        .st_q    (st_q),
        .ready_o (req_ready),
        .cap_o   (cap)
    );

    sram_pin_reg u_pins (
        .clk        (clk),
        .rst        (rst),
        .st_i       (st_q),
        .cs_frame_i (mode_q),
        .cap_i      (cap),
        .cs_n       (mem_cs_n),
        .oe_n       (mem_oe_n),
        .we_n       (mem_we_n),
        .drv        (mem_dq_oe),
        .cap_q      (cap_q)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .cap_i     (cap_q),
        .dq_in     (mem_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/sram_port_chk.sv
`timescale 1ns/1ps
module sram_port_chk #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int N_HZ   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    localparam int GW = $clog2(N_HZ + 2);

    // Cycles since the memory was last allowed to drive, saturating at N_HZ.
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst)                       gap_q <= GW'(N_HZ);
        else if (!mem_cs_n && !mem_oe_n) gap_q <= '0;
        else if (gap_q < GW'(N_HZ))    gap_q <= gap_q + 1'b1;
    end

    assert_quiet_reset_R1: assert property (@(posedge clk)
        rst |=> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid));

    assert_one_per_handshake_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_no_bus_fight_R4: assert property (@(posedge clk) disable iff (rst)
        !(mem_dq_oe && !mem_cs_n && !mem_oe_n));

    assert_turnaround_gap_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (gap_q >= GW'(N_HZ)));

    assert_oe_off_in_write_R5: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    assert_addr_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !mem_we_n) |=> (mem_cs_n || mem_we_n || $stable(mem_addr)));

    assert_data_in_overlap_R9: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !mem_we_n) |-> mem_dq_oe);

    assert_data_steady_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

endmodule

bind sram_port_ctl sram_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_HZ(N_HZ)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_sram_port_ctl.sv
`timescale 1ns/1ps
module sim_sram_port_ctl;

    localparam int AW    = 10;
    localparam int DW    = 8;
    localparam int CLK   = 4;
    localparam int DEPTH = 1 << AW;

    function automatic int up(input int ns);
        return (ns + CLK - 1) / CLK;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected cycle counts from the default nanosecond values.
    localparam int N_RD  = mx(mx(up(20), up(20)), mx(up(10), up(20)));
    localparam int N_WP  = mx(mx(up(12), up(15)), mx(up(12), up(10)));
    localparam int N_REC = mx(1, mx(mx(up(2), up(1)), up(20) - 1 - N_WP));
    localparam int N_HZ  = up(7);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0, req_wmode = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;

    int total = 0;
    int bad   = 0;

    always #(CLK / 2) clk = ~clk;

    sram_port_ctl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_wmode  (req_wmode),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .mem_addr   (mem_addr),
        .mem_cs_n   (mem_cs_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

    // Memory model: drives only while selected, output enabled and not writing.
    logic [DW-1:0] mem [0:DEPTH-1];
    assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n) ? mem[mem_addr] : '0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int ph);
        return (ph == 0) ? DW'((a * 37 + 11) % 256) : DW'(255 - ((a * 91 + 3) % 256));
    endfunction

    // Pin monitor, sampled at falling edges.
    bit            cur_mode = 1'b0;
    int            ovl_n = 0, rd_n = 0, gap_n = 100;
    logic          prev_cs = 1'b1, prev_we = 1'b1, prev_dq = 1'b0;
    logic [AW-1:0] ovl_addr = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_dq_oe && !mem_cs_n && !mem_oe_n)
                check(1'b0, "R4 driver on while memory drives", 1, 0);
            if (mem_dq_oe && !prev_dq)
                check(gap_n >= N_HZ, "R4 turnaround gap", gap_n, N_HZ);
            if (!mem_we_n && !mem_oe_n)
                check(1'b0, "R5 output enable low in write", 0, 1);

            if (!mem_cs_n && !mem_we_n) begin
                if (ovl_n == 0) begin
                    if (cur_mode)
                        check(prev_cs && !prev_we, "R7 write-enable leads", {prev_cs, prev_we}, 2'b10);
                    else
                        check(!prev_cs && prev_we, "R6 select leads", {prev_cs, prev_we}, 2'b01);
                    ovl_addr = mem_addr;
                end else if (mem_addr != ovl_addr) begin
                    check(1'b0, "R8 address moved in overlap", mem_addr, ovl_addr);
                end
                if (!mem_dq_oe) check(1'b0, "R9 driver off in overlap", 0, 1);
                mem[mem_addr] <= mem_dq_out;
                ovl_n++;
            end else if (ovl_n != 0) begin
                check(ovl_n == N_WP, "R6 overlap length", ovl_n, N_WP);
                check(mem_dq_oe, "R9 data held after overlap", mem_dq_oe, 1);
                if (cur_mode)
                    check(mem_cs_n && !mem_we_n, "R7 select rises first", {mem_cs_n, mem_we_n}, 2'b10);
                else
                    check(!mem_cs_n && mem_we_n, "R6 write-enable rises first", {mem_cs_n, mem_we_n}, 2'b01);
                ovl_n = 0;
            end

            if (!mem_cs_n && !mem_oe_n) begin
                rd_n++;
            end else if (rd_n != 0) begin
                check(rd_n == N_RD, "R3 read window", rd_n, N_RD);
                rd_n = 0;
            end
            gap_n = (!mem_cs_n && !mem_oe_n) ? 0 : gap_n + 1;
            if (gap_n > 100) gap_n = 100;
        end
        prev_cs = mem_cs_n;
        prev_we = mem_we_n;
        prev_dq = mem_dq_oe;
    end

    task automatic do_req(input bit wr, input bit md, input int a, input logic [DW-1:0] d,
                          output int busy, output int strobes, output logic [DW-1:0] got);
        @(negedge clk);
        cur_mode  = md;
        req_write = wr;
        req_wmode = md;
        req_addr  = AW'(a);
        req_wdata = d;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0;
        strobes = 0;
        got = '0;
        forever begin
            if (rsp_valid) begin
                strobes++;
                got = rsp_rdata;
            end
            if (req_ready) break;
            busy++;
            @(negedge clk);
        end
        @(negedge clk);
        if (rsp_valid) strobes++;
        check(mem_cs_n && mem_we_n && !mem_dq_oe, "R2 pins idle after transaction",
              {mem_cs_n, mem_we_n, mem_dq_oe}, 3'b110);
    endtask

    task automatic write_pass(input int ph, input bit desc);
        int busy, strobes;
        logic [DW-1:0] got;
        for (int i = 0; i < DEPTH; i++) begin
            int a;
            a = desc ? (DEPTH - 1 - i) : i;
            do_req(1'b1, (a % 2 == 1) ^ (ph == 1), a, pat(a, ph), busy, strobes, got);
            check(busy == 1 + N_WP + N_REC, "R11 write busy cycles", busy, 1 + N_WP + N_REC);
            if (strobes != 0) check(1'b0, "R3 strobe on write", strobes, 0);
        end
    endtask

    task automatic read_pass(input int ph, input bit desc);
        int busy, strobes;
        logic [DW-1:0] got;
        for (int i = 0; i < DEPTH; i++) begin
            int a;
            a = desc ? (DEPTH - 1 - i) : i;
            do_req(1'b0, 1'b0, a, '0, busy, strobes, got);
            check(busy == N_RD + N_HZ, "R11 read busy cycles", busy, N_RD + N_HZ);
            check(strobes == 1, "R3 one response strobe", strobes, 1);
            check(got == pat(a, ph), "R10 read-back", got, pat(a, ph));
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = DW'(i ^ 8'h5a);
        repeat (2) @(negedge clk);
        // R1: reset levels while reset is held
        check(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes high in reset",
              {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
        check(!mem_dq_oe, "R1 driver off in reset", mem_dq_oe, 0);
        check(req_ready && !rsp_valid, "R1 ready high, strobe low", {req_ready, rsp_valid}, 2'b10);
        rst = 1'b0;
        @(negedge clk);
        check(mem_cs_n && !mem_dq_oe && req_ready, "R1 state after reset",
              {mem_cs_n, mem_dq_oe, req_ready}, 3'b101);

        write_pass(0, 1'b0);
        read_pass(0, 1'b0);
        write_pass(1, 1'b1);
        read_pass(1, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule